// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block sits between one processor's load/store path and a synchronous memory port. It gives load-locked and store-conditional operations their atomic meaning. It keeps a single reservation, which is an address together with the data word that was read there. A load-locked operation fills the reservation and returns the word. A store-conditional operation writes only if the reservation still covers its exact address and memory still holds the word that was captured. It answers 1 on success and 0 on failure.

The store-conditional re-read and the write that may follow it run as one locked sequence, and `mem_lock` tells the memory arbiter to keep other masters out for that time. The processor signals trap-return events, and these drop the reservation. Debug and single-step events leave it alone. Plain loads and stores go through to memory and never touch the reservation. The block handles one operation at a time. `busy` covers each operation from the cycle after acceptance to its response. A parameter can place a register stage in the value comparison to shorten the path from read data to the write decision.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `mem_req` and `mem_lock` are low and no reservation exists, so a store-conditional issued first returns 0, makes no memory access and leaves memory unchanged.
- R2: A plain load (`req_op` 0) returns the memory word at its address. A plain store (`req_op` 1) writes its data and responds with 0. Neither one creates, drops or alters the reservation.
- R3: A load-locked operation (`req_op` 2) returns the memory word and records both its address and that word as the reservation.
- R4: A store-conditional (`req_op` 3) whose address differs from the reservation address in any bit returns 0 and issues no memory request.
- R5: A store-conditional whose address matches re-reads memory. It writes its data and returns 1 only if the re-read word equals the recorded word; otherwise it returns 0 and memory is unchanged. The test is on the value alone, so a word that was changed and then changed back still passes.
- R6: Every store-conditional drops the reservation whatever its result, so a second store-conditional to the same address returns 0.
- R7: An event with `evt_kind` 0 (trap return) drops the reservation. Kinds 1 (single step), 2 (debug stop) and 3 (reserved) have no effect on it.
- R8: The all-ones address marks an empty reservation. A store-conditional to the all-ones address never succeeds, even right after a load-locked to that address.
- R9: During a matching store-conditional, `mem_lock` is high from the re-read request through the write request. The re-read is the first request of the locked sequence, and each memory request lasts one cycle.
- R10: `busy` is high from the cycle after a request is accepted until the response cycle. Requests presented while `busy` is high are ignored. `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 2 | 0 load, 1 store, 2 load-locked, 3 store-conditional |
| req_addr | input | ADDR_W | Physical address of the request |
| req_wdata | input | DATA_W | Store data |
| evt_valid | input | 1 | Processor event strobe |
| evt_kind | input | 2 | 0 trap return, 1 single step, 2 debug stop, 3 reserved |
| busy | output | 1 | An operation is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Load data, store-conditional flag, or 0 for a store |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_lock | output | 1 | Arbiter hold for the store-conditional sequence |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the block with an 8-bit address, which puts the all-ones sentinel address 0xFF within reach of a normal request and keeps a complete memory model down to 256 words. It also sets the registered value comparison, so store-conditionals go through the extra compare state. The bench memory can insert extra read latency, and it lets the bench change a word from outside between a load-locked and its store-conditional. This reaches the value-mismatch case and the changed-then-restored case.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   typedef enum logic [1:0] {
      OP_LD = 2'd0,
      OP_ST = 2'd1,
      OP_LL = 2'd2,
      OP_SC = 2'd3
   } llsc_op_e;

   typedef enum logic [1:0] {
      EV_TRAP_RET = 2'd0,
      EV_STEP     = 2'd1,
      EV_DEBUG    = 2'd2,
      EV_RSVD     = 2'd3
   } llsc_evt_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_RWAIT = 3'd2,
      ST_CHK   = 3'd3,
      ST_WR    = 3'd4,
      ST_RSP   = 3'd5
   } llsc_state_e;

endpackage

// File: rtl/llsc_resv.sv
// Reservation holder: address plus captured word; all-ones address = empty.
module llsc_resv #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              kill,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              hit,
   output logic [DATA_W-1:0] resv_data
);

   localparam logic [ADDR_W-1:0] NO_RESV = '1;

   logic [ADDR_W-1:0] resv_addr;

   // kill has priority: a trap in the same cycle as a capture leaves it empty
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resv_addr <= NO_RESV;
         resv_data <= '0;
      end else if (kill) begin
         resv_addr <= NO_RESV;
      end else if (cap_en) begin
         resv_addr <= cap_addr;
         resv_data <= cap_data;
      end
   end

   assign hit = (probe_addr == resv_addr) && (resv_addr != NO_RESV);

endmodule

// File: rtl/llsc_vcmp.sv
// Value comparison of re-read data against the captured word.
// REG_CMP = 0: combinational; REG_CMP = 1: one register stage.
module llsc_vcmp #(
   parameter int DATA_W  = 64,
   parameter int REG_CMP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] ref_data,
   output logic              out_vld,
   output logic              out_eq
);

   logic eq_raw;
   assign eq_raw = (in_data == ref_data);

   if (REG_CMP != 0) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_vld <= 1'b0;
            out_eq  <= 1'b0;
         end else begin
            out_vld <= in_vld;
            out_eq  <= eq_raw;
         end
      end
   end else begin : g_comb
      assign out_vld = in_vld;
      assign out_eq  = eq_raw;
   end

endmodule

// File: rtl/llsc_seq.sv
// Operation sequencer: one request at a time, memory side handshake.
module llsc_seq
   import llsc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int REG_CMP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              resv_hit,
   input  logic              cmp_vld,
   input  logic              cmp_eq,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_lock,
   output logic              cap_en,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data,
   output logic              sc_kill
);

   localparam logic [DATA_W-1:0] SC_PASS = DATA_W'(1);

   llsc_state_e       state, state_n;
   llsc_op_e          op_q, op_n, op_in;
   logic [ADDR_W-1:0] addr_q, addr_n;
   logic [DATA_W-1:0] wdata_q, wdata_n;
   logic [DATA_W-1:0] rsp_q, rsp_n;
   logic              accept;

   assign op_in  = llsc_op_e'(req_op);
   assign accept = req_valid && (state == ST_IDLE);

   always_comb begin
      state_n = state;
      op_n    = op_q;
      addr_n  = addr_q;
      wdata_n = wdata_q;
      rsp_n   = rsp_q;
      case (state)
         ST_IDLE: begin
            if (req_valid) begin
               op_n    = op_in;
               addr_n  = req_addr;
               wdata_n = req_wdata;
               rsp_n   = '0;
               case (op_in)
                  OP_ST:   state_n = ST_WR;
                  OP_SC:   state_n = resv_hit ? ST_RD : ST_RSP;
                  default: state_n = ST_RD;
               endcase
            end
         end
         ST_RD: state_n = ST_RWAIT;
         ST_RWAIT: begin
            if (mem_rvalid) begin
               if (op_q == OP_SC) begin
                  if (REG_CMP != 0) state_n = ST_CHK;
                  else              state_n = (cmp_vld && cmp_eq) ? ST_WR : ST_RSP;
               end else begin
                  rsp_n   = mem_rdata;
                  state_n = ST_RSP;
               end
            end
         end
         ST_CHK: begin
            if (cmp_vld) state_n = cmp_eq ? ST_WR : ST_RSP;
         end
         ST_WR: begin
            state_n = ST_RSP;
            if (op_q == OP_SC) rsp_n = SC_PASS;
         end
         ST_RSP:  state_n = ST_IDLE;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_LD;
         addr_q  <= '0;
         wdata_q <= '0;
         rsp_q   <= '0;
      end else begin
         state   <= state_n;
         op_q    <= op_n;
         addr_q  <= addr_n;
         wdata_q <= wdata_n;
         rsp_q   <= rsp_n;
      end
   end

   assign busy      = (state != ST_IDLE);
   assign rsp_valid = (state == ST_RSP);
   assign rsp_data  = rsp_q;

   assign mem_req   = (state == ST_RD) || (state == ST_WR);
   assign mem_we    = (state == ST_WR);
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign mem_lock  = (op_q == OP_SC) &&
                      ((state == ST_RD) || (state == ST_RWAIT) ||
                       (state == ST_CHK) || (state == ST_WR));

   assign cap_en    = (state == ST_RWAIT) && mem_rvalid && (op_q == OP_LL);
   assign cap_addr  = addr_q;
   assign cap_data  = mem_rdata;
   assign sc_kill   = accept && (op_in == OP_SC);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int REG_CMP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              evt_valid,
   input  logic [1:0]        evt_kind,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_lock,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
      $error("llsc_monitor: ADDR_W must lie in 2..64");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("llsc_monitor: DATA_W must be positive");
   end
   if (REG_CMP != 0 && REG_CMP != 1) begin : g_bad_reg_cmp
      $error("llsc_monitor: REG_CMP must be 0 or 1");
   end

   logic              resv_hit;
   logic [DATA_W-1:0] resv_data;
   logic              cmp_vld, cmp_eq;
   logic              cap_en, sc_kill, trap_clr;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;

   assign trap_clr = evt_valid && (llsc_evt_e'(evt_kind) == EV_TRAP_RET);

   llsc_resv #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_en),
      .cap_addr   (cap_addr),
      .cap_data   (cap_data),
      .kill       (sc_kill || trap_clr),
      .probe_addr (req_addr),
      .hit        (resv_hit),
      .resv_data  (resv_data)
   );

   llsc_vcmp #(
      .DATA_W  (DATA_W),
      .REG_CMP (REG_CMP)
   ) i_vcmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (mem_rvalid),
      .in_data  (mem_rdata),
      .ref_data (resv_data),
      .out_vld  (cmp_vld),
      .out_eq   (cmp_eq)
   );

   llsc_seq #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .REG_CMP (REG_CMP)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .resv_hit   (resv_hit),
      .cmp_vld    (cmp_vld),
      .cmp_eq     (cmp_eq),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .busy       (busy),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_lock   (mem_lock),
      .cap_en     (cap_en),
      .cap_addr   (cap_addr),
      .cap_data   (cap_data),
      .sc_kill    (sc_kill)
   );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic rsp_valid,
   input logic mem_req,
   input logic mem_we,
   input logic mem_lock
);

   // R10
   rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R10
   rsp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> busy);

   // R1
   mem_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R9
   lock_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_lock) |-> (mem_req && !mem_we));

   // R9
   lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> busy);

   // R9
   lock_ends_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && mem_req && mem_we) |=> !mem_lock);

   // R9
   mem_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

endmodule

bind llsc_monitor llsc_monitor_chk i_llsc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .rsp_valid (rsp_valid),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_lock  (mem_lock)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;

   localparam int AW = 8;
   localparam int DW = 64;
   localparam int NW = 1 << AW;
   localparam logic [AW-1:0] ALL1 = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          evt_valid = 1'b0;
   logic [1:0]    evt_kind = 2'd0;
   logic          busy, rsp_valid, mem_req, mem_we, mem_lock;
   logic [DW-1:0] rsp_data, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic          mem_rvalid;
   logic [DW-1:0] mem_rdata;

   always #2 clk = ~clk;

   llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .REG_CMP(1)) i_llsc_monitor (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .evt_valid(evt_valid),
      .evt_kind(evt_kind), .busy(busy), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_lock(mem_lock),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] init_val(int i);
      return 64'h5A00_0000_0000_0000 + 64'(i) * 64'h0001_0203;
   endfunction

   // ---------------- memory model ----------------
   logic [DW-1:0] mem [NW];
   logic          pend;
   int            pcnt;
   logic [AW-1:0] paddr;
   int            extra_lat = 0;
   int            req_cnt;
   logic          last_wr_locked;
   logic          poke_en = 1'b0;
   logic [AW-1:0] poke_addr = '0;
   logic [DW-1:0] poke_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) mem[i] <= init_val(i);
         pend <= 1'b0; pcnt <= 0; paddr <= '0;
         mem_rvalid <= 1'b0; mem_rdata <= '0;
         req_cnt <= 0; last_wr_locked <= 1'b0;
      end else begin
         mem_rvalid <= 1'b0;
         if (pend) begin
            if (pcnt == 0) begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= mem[paddr];
               pend       <= 1'b0;
            end else pcnt <= pcnt - 1;
         end
         if (poke_en) mem[poke_addr] <= poke_data;
         if (mem_req) req_cnt <= req_cnt + 1;
         if (mem_req && mem_we) begin
            mem[mem_addr]  <= mem_wdata;
            last_wr_locked <= mem_lock;
         end
         if (mem_req && !mem_we) begin
            pend <= 1'b1; pcnt <= extra_lat; paddr <= mem_addr;
         end
      end
   end

   // ---------------- checking ----------------
   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                        input string tag);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   // monitor: pop expected item on each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 unexpected response actual=%h expected=none", rsp_data);
         end else begin
            check(rsp_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   // ---------------- reference model ----------------
   logic [DW-1:0] m_mem [NW];
   logic          m_rv = 1'b0;
   logic [AW-1:0] m_raddr = '0;
   logic [DW-1:0] m_rval = '0;

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] exp,
                        input string tag);
      @(negedge clk);
      while (busy) @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || busy) @(negedge clk);
   endtask

   task automatic ld(input logic [AW-1:0] a, input string tag);
      issue(2'd0, a, '0, m_mem[a], tag);
   endtask

   task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      m_mem[a] = d;
      issue(2'd1, a, d, '0, tag);
   endtask

   task automatic ll(input logic [AW-1:0] a, input string tag);
      m_rv = (a != ALL1); m_raddr = a; m_rval = m_mem[a];
      issue(2'd2, a, '0, m_mem[a], tag);
   endtask

   task automatic sc(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      logic ok;
      ok = m_rv && (a == m_raddr) && (m_mem[a] == m_rval);
      if (ok) m_mem[a] = d;
      m_rv = 1'b0;
      issue(2'd3, a, d, DW'(ok), tag);
   endtask

   task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_addr = a; poke_data = d;
      m_mem[a] = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic event_pulse(input logic [1:0] k);
      @(negedge clk);
      evt_valid = 1'b1; evt_kind = k;
      if (k == 2'd0) m_rv = 1'b0;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

   initial begin
      int rc;
      for (int i = 0; i < NW; i++) m_mem[i] = init_val(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(DW'(busy), 0, "R1 busy");
      check(DW'(rsp_valid), 0, "R1 rsp_valid");
      check(DW'(mem_req), 0, "R1 mem_req");
      check(DW'(mem_lock), 0, "R1 mem_lock");
      rc = req_cnt;
      sc(8'h10, 64'hDEAD, "R1 sc after reset");
      drain();
      check(DW'(req_cnt - rc), 0, "R1 no access");
      ld(8'h10, "R1 memory unchanged");

      // R2 plain loads and stores
      ld(8'h01, "R2 load");
      ld(8'h02, "R2 load");
      st(8'h20, 64'h0123_4567_89AB_CDEF, "R2 store rsp");
      ld(8'h20, "R2 load after store");

      // R3 / R5 / R9 successful pair
      ll(8'h30, "R3 ll data");
      sc(8'h30, 64'hCAFE_0030, "R5 sc pass");
      drain();
      check(DW'(last_wr_locked), 1, "R9 write under lock");
      ld(8'h30, "R5 written");

      // R6 second sc fails
      sc(8'h30, 64'hBAD0, "R6 sc after sc");
      ld(8'h30, "R6 unchanged");

      // R4 address mismatch
      ll(8'h40, "R3 ll");
      drain();
      rc = req_cnt;
      sc(8'h41, 64'hBAD1, "R4 sc other addr");
      drain();
      check(DW'(req_cnt - rc), 0, "R4 no memory request");
      sc(8'h40, 64'hBAD2, "R6 failed sc also drops");
      ld(8'h41, "R4 unchanged");

      // R5 value changed by another agent, with slower memory
      extra_lat = 2;
      ll(8'h50, "R3 ll slow");
      drain();
      poke(8'h50, 64'h7777);
      sc(8'h50, 64'hBAD3, "R5 value changed");
      ld(8'h50, "R5 poked value kept");

      // R5 changed and restored
      ll(8'h60, "R3 ll");
      drain();
      poke(8'h60, 64'h1);
      poke(8'h60, init_val(8'h60));
      sc(8'h60, 64'hABA0, "R5 restored value passes");
      ld(8'h60, "R5 written");
      extra_lat = 0;

      // R2 plain ops in between leave reservation
      ll(8'h70, "R3 ll");
      st(8'h71, 64'h71, "R2 store other");
      ld(8'h72, "R2 load other");
      sc(8'h70, 64'h7070, "R2 reservation kept");

      // R2 / R5 store to reserved word changes value
      ll(8'hA0, "R3 ll");
      st(8'hA0, 64'hA0A0, "R2 store reserved");
      sc(8'hA0, 64'hBAD4, "R5 value differs after store");
      ld(8'hA0, "R2 store data kept");

      // R7 events
      ll(8'h80, "R3 ll");
      drain();
      event_pulse(2'd1);
      event_pulse(2'd2);
      event_pulse(2'd3);
      sc(8'h80, 64'h8080, "R7 non-trap events keep");
      ll(8'h90, "R3 ll");
      drain();
      event_pulse(2'd0);
      sc(8'h90, 64'hBAD5, "R7 trap return drops");
      ld(8'h90, "R7 unchanged");

      // R8 all-ones address
      ll(ALL1, "R8 ll all-ones");
      sc(ALL1, 64'hBAD6, "R8 sc all-ones fails");
      ld(ALL1, "R8 unchanged");

      // R10 request while busy ignored
      drain();
      issue(2'd0, 8'hB0, '0, m_mem[8'hB0], "R10 load");
      check(DW'(busy), 1, "R10 busy during op");
      req_valid = 1'b1; req_op = 2'd1; req_addr = 8'hB1; req_wdata = 64'hBAD7;
      @(negedge clk);
      req_valid = 1'b0;
      drain();
      ld(8'hB1, "R10 ignored store");
      drain();
      check(DW'(busy), 0, "R10 idle after response");

      repeat (5) @(negedge clk);
      report();
   end

endmodule